// File: doc/BRIEF.md
# Linear Interpolating Output Upsampler

This block raises the rate at which output values are produced above the rate at which samples are stored. For every stored sample period it emits a fixed number of output values, so that a pulse-width modulator driven by it runs with its carrier above the audio band. The emitted values do not repeat the stored sample. They crossfade linearly from the current stored sample to the following one, which replaces an abrupt step at each storage period with a sequence of small steps.

An upstream reader presents two adjacent stored samples: the one at its read index and the one at the read index plus one, wrapped around the buffer size. On every output tick the block picks two weights from its phase index, scales each operand, and registers their sum. Each operand is first divided by the factor with a right shift. The current sample is weighted by the factor minus the phase and the next sample by the phase. The phase index then steps forward. When the phase wraps back to zero, the block raises a one-cycle advance pulse so that the reader steps its read index. Both divisions are shifts and both weights are small, so the products come from shift-and-add logic with no general multiplier.

Top module: `upsampler`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_value`, `out_valid`, `phase` and `advance` are all 0.
- R2: `phase` increases by one in the cycle after each cycle with `tick` high. After FACTOR-1 it goes back to 0. It does not change in any cycle that follows a cycle with `tick` low.
- R3: In the cycle after a tick, `out_value` equals (cur>>S)*(FACTOR-k) + (nxt>>S)*k. Here k is the phase before that tick, S is log2(FACTOR), and cur and nxt are the inputs sampled on the tick. With FACTOR=4, S is 2.
- R4: At phase 0 the output equals the current sample with its S low bits cleared. The next sample has no effect on it.
- R5: `out_valid` is high for exactly the one cycle after each tick and low otherwise.
- R6: `advance` is a one-cycle pulse. It is high in the cycle after a tick taken at phase FACTOR-1, and `phase` is 0 in that same cycle. It is low in every other cycle.
- R7: Between ticks, `out_value` is held. Changes on `cur_sample` or `nxt_sample` while `tick` is low have no effect on it.
- R8: With both inputs at their full-scale value 0xFFFF, every phase yields 0xFFFC. The weighted sum never wraps past DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Output update strobe, one cycle per output value |
| cur_sample | input | DATA_W | Stored sample at the read index |
| nxt_sample | input | DATA_W | Stored sample at read index + 1 (wrapped) |
| out_value | output | DATA_W | Interpolated output, held between ticks |
| out_valid | output | 1 | High for the cycle in which a new output appears |
| phase | output | $clog2(FACTOR) | Current phase index k |
| advance | output | 1 | One-cycle pulse telling the reader to step its index |

## Verification
The bench builds the block with DATA_W=16 and FACTOR=4. With these values the phase takes all four states, and the wrap from 3 to 0 together with its advance pulse occurs on every fourth tick. The full-scale inputs 0xFFFF reach the largest weighted sum, so any loss of carry or overflow in the shift-and-add tree shows up at the output. Operand pairs whose low two bits differ show whether the truncation happens before the weighting.

// File: rtl/upsampler_pkg.sv
package upsampler_pkg;

    localparam int UPS_DATA_W = 16;
    localparam int UPS_FACTOR = 4;

    // Width able to hold the values 0..factor inclusive
    function automatic int weight_width(input int factor);
        return $clog2(factor) + 1;
    endfunction

    // Width of the phase index 0..factor-1
    function automatic int phase_width(input int factor);
        return (factor > 2) ? $clog2(factor) : 1;
    endfunction

endpackage

// File: rtl/upsampler_phase_ctr.sv
module upsampler_phase_ctr #(
    parameter int FACTOR = upsampler_pkg::UPS_FACTOR,
    localparam int PW = upsampler_pkg::phase_width(FACTOR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] k,
    output logic          at_last
);
    localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);

    assign at_last = (k == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            k <= '0;
        end else if (step) begin
            k <= at_last ? '0 : k + 1'b1;
        end
    end
endmodule

// File: rtl/upsampler_shift_add.sv
module upsampler_shift_add #(
    parameter int DATA_W = upsampler_pkg::UPS_DATA_W,
    parameter int WW     = 3
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [WW-1:0]     weight,
    output logic [DATA_W-1:0] product
);
    logic [DATA_W-1:0] partial [WW];

    for (genvar b = 0; b < WW; b++) begin : g_term
        assign partial[b] = weight[b] ? (operand << b) : '0;
    end

    always_comb begin
        product = '0;
        for (int b = 0; b < WW; b++) begin
            product = product + partial[b];
        end
    end
endmodule

// File: rtl/upsampler_out_reg.sv
module upsampler_out_reg #(
    parameter int DATA_W = upsampler_pkg::UPS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              wrap,
    input  logic [DATA_W-1:0] next_value,
    output logic [DATA_W-1:0] value,
    output logic              valid,
    output logic              adv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            valid <= 1'b0;
            adv   <= 1'b0;
        end else begin
            valid <= load;
            adv   <= load & wrap;
            if (load) begin
                value <= next_value;
            end
        end
    end
endmodule

// File: rtl/upsampler.sv
module upsampler #(
    parameter int DATA_W = upsampler_pkg::UPS_DATA_W,
    parameter int FACTOR = upsampler_pkg::UPS_FACTOR,
    localparam int PW = upsampler_pkg::phase_width(FACTOR),
    localparam int WW = upsampler_pkg::weight_width(FACTOR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] cur_sample,
    input  logic [DATA_W-1:0] nxt_sample,
    output logic [DATA_W-1:0] out_value,
    output logic              out_valid,
    output logic [PW-1:0]     phase,
    output logic              advance
);
    localparam int SHIFT = $clog2(FACTOR);

    logic              last_phase;
    logic [DATA_W-1:0] cur_div, nxt_div;
    logic [WW-1:0]     w_cur, w_nxt;
    logic [DATA_W-1:0] p_cur, p_nxt, blend;

    upsampler_phase_ctr #(.FACTOR(FACTOR)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .step    (tick),
        .k       (phase),
        .at_last (last_phase)
    );

    // Pre-division by the factor (factor is a power of two)
    assign cur_div = cur_sample >> SHIFT;
    assign nxt_div = nxt_sample >> SHIFT;

    // Crossfade weights: current fades out, next fades in
    assign w_nxt = WW'(phase);
    assign w_cur = WW'(FACTOR) - w_nxt;

    upsampler_shift_add #(.DATA_W(DATA_W), .WW(WW)) u_mul_cur (
        .operand (cur_div),
        .weight  (w_cur),
        .product (p_cur)
    );

    upsampler_shift_add #(.DATA_W(DATA_W), .WW(WW)) u_mul_nxt (
        .operand (nxt_div),
        .weight  (w_nxt),
        .product (p_nxt)
    );

    assign blend = p_cur + p_nxt;

    upsampler_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (tick),
        .wrap       (last_phase),
        .next_value (blend),
        .value      (out_value),
        .valid      (out_valid),
        .adv        (advance)
    );
endmodule

// File: rtl/upsampler_chk.sv
module upsampler_chk #(
    parameter int DATA_W = 16,
    parameter int FACTOR = 4,
    parameter int PW = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [DATA_W-1:0] cur_sample,
    input logic [DATA_W-1:0] out_value,
    input logic              out_valid,
    input logic [PW-1:0]     phase,
    input logic              advance
);
    localparam int SHIFT = $clog2(FACTOR);
    localparam logic [DATA_W-1:0] KEEP = ~DATA_W'((1 << SHIFT) - 1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (out_value == '0 && !out_valid && phase == '0 && !advance));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && phase != PW'(FACTOR - 1)) |=> phase == $past(phase) + 1'b1);

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && phase == PW'(FACTOR - 1)) |=> phase == '0);

    assert_phase_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));

    assert_phase0_cur_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && phase == '0) |=> out_value == ($past(cur_sample) & KEEP));

    assert_valid_tick_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> out_valid);

    assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !out_valid);

    assert_advance_phase_R6: assert property (@(posedge clk) disable iff (rst)
        advance |-> phase == '0);

    assert_advance_single_R6: assert property (@(posedge clk) disable iff (rst)
        advance |=> !advance);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(out_value));
endmodule

bind upsampler upsampler_chk #(.DATA_W(DATA_W), .FACTOR(FACTOR), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cur_sample (cur_sample),
    .out_value  (out_value),
    .out_valid  (out_valid),
    .phase      (phase),
    .advance    (advance)
);

// File: tb/tb_upsampler.sv
module tb_upsampler;
    localparam int DW = 16;
    localparam int F  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [DW-1:0] cur_sample = '0;
    logic [DW-1:0] nxt_sample = '0;
    logic [DW-1:0] out_value;
    logic          out_valid;
    logic [1:0]    phase;
    logic          advance;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_k   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    upsampler #(.DATA_W(DW), .FACTOR(F)) dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sample(cur_sample), .nxt_sample(nxt_sample),
        .out_value(out_value), .out_valid(out_valid),
        .phase(phase), .advance(advance)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input int c, input int n, input int k);
        return (c >> 2) * (F - k) + (n >> 2) * k;
    endfunction

    // One tick with given operands; checks the results in the following cycle
    task automatic do_tick(input int c, input int n, input string req);
        int e;
        @(negedge clk);
        tick = 1'b1; cur_sample = DW'(c); nxt_sample = DW'(n);
        e = model(c, n, exp_k) & 16'hFFFF;
        @(negedge clk);
        tick = 1'b0;
        check(req, "out_value", int'(out_value), e);
        check("R5", "out_valid after tick", int'(out_valid), 1);
        check("R6", "advance", int'(advance), (exp_k == F - 1) ? 1 : 0);
        exp_k = (exp_k + 1) % F;
        check("R2", "phase", int'(phase), exp_k);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "out_value in reset", int'(out_value), 0);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "phase in reset", int'(phase), 0);
        check("R1", "advance in reset", int'(advance), 0);
        rst = 1'b0;
        exp_k = 0;
        @(negedge clk);
        check("R1", "out_value after release", int'(out_value), 0);
        check("R1", "phase after release", int'(phase), 0);
    endtask

    task automatic t_ramp();
        // R3: rising pair, four phases
        for (int i = 0; i < F; i++) do_tick(1000, 2000, "R3");
        // R3: falling pair with odd low bits
        for (int i = 0; i < F; i++) do_tick(40003, 1237, "R3");
    endtask

    task automatic t_phase0();
        // R4: phase 0 ignores next sample, clears low bits
        check("R4", "at phase 0 before test", int'(phase), 0);
        do_tick(16'h1237, 16'hFFFF, "R4");
        check("R4", "phase0 value", int'(out_value), 16'h1234);
        for (int i = 1; i < F; i++) do_tick(16'h1237, 16'hFFFF, "R3");
    endtask

    task automatic t_hold();
        int held;
        do_tick(5000, 9000, "R3");
        held = int'(out_value);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cur_sample = DW'(i * 777); nxt_sample = DW'(60000 - i);
            check("R7", "held value", int'(out_value), held);
            check("R5", "valid idle", int'(out_valid), 0);
            check("R6", "advance idle", int'(advance), 0);
        end
        check("R2", "phase idle", int'(phase), exp_k);
        while (exp_k != 0) do_tick(5000, 9000, "R3");
    endtask

    task automatic t_fullscale();
        for (int i = 0; i < F; i++) begin
            do_tick(16'hFFFF, 16'hFFFF, "R8");
            check("R8", "full scale", int'(out_value), 16'hFFFC);
        end
    endtask

    task automatic t_gapped();
        // Ticks spaced by idle cycles: wrap and advance still follow ticks
        for (int i = 0; i < 2 * F; i++) begin
            do_tick(i * 4096, (i + 1) * 4096 - 1, "R3");
            repeat (i % 3) @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_phase0();
        t_hold();
        t_fullscale();
        t_gapped();
        t_reset();
        do_tick(888, 444, "R3");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule